// File: doc/BRIEF.md
# Microprogrammed Motion Command Sequencer

This block steps through a small program of motion commands held in a parameter ROM. A micro program counter selects one microinstruction per step. Each word carries an opcode, an 8-bit argument and a jump target. Motion words are presented to an external actuator as a command with a valid/done handshake, and the counter stays on that word until the actuator reports completion. Control words execute in one cycle and issue no command. They are a conditional branch that tests a sensor input reporting a clear path, and an unconditional jump. With these, a looping motion program can react to obstacles.

A next-address multiplexer picks either the incremented counter or the target field of the current word. A small decoder drives that choice from the opcode, the handshake and the sensor. The default program drives forward, repeats while the path stays clear, and otherwise backs up, turns and checks again.

Top module: `motion_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the counter is set to address 0, and `cmdValid` is low for as long as `rst` is high. After release, the first command presented is the word at address 0.
- R2: Word i of `PROG` sits at bits [i*W +: W], with W = 3 + ARG_W + ADDR_W (14 by default). Within a word, the opcode is the top 3 bits, the argument is the next ARG_W bits, and the target is the low ADDR_W bits. Opcodes are: 0 forward, 1 back, 2 rotate, 3 branch-if-clear, 4 jump. Values 5 to 7 are undefined.
- R3: On a motion word (opcodes 0 to 2), `cmdValid` is high and shows that word's opcode and argument. All three hold unchanged while `cmdDone` stays low.
- R4: When `cmdValid` and `cmdDone` are high at a rising edge, the counter advances by one. The following word is presented in the next cycle.
- R5: A branch-if-clear word takes one cycle with `cmdValid` low. If `noObstacle` is high in that cycle, the counter loads the target field.
- R6: If `noObstacle` is low during a branch-if-clear word, the counter advances by one.
- R7: A jump word takes one cycle with `cmdValid` low and always loads the target field.
- R8: An undefined opcode (5 to 7) takes one cycle with `cmdValid` low and advances the counter by one.
- R9: `cmdDone` has no effect on any cycle in which `cmdValid` is low.
- R10: Advancing from the last address (2^ADDR_W − 1) wraps the counter to address 0.
- R11: The default program is:
  - address 0: forward 35
  - address 1: branch-if-clear to 0
  - address 2: back 10
  - address 3: rotate 90
  - address 4: jump to 1
  - addresses 5 to 7: jump to 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| noObstacle | input | 1 | Sensor: path is clear, tested by branch-if-clear |
| cmdDone | input | 1 | Actuator reports that the current command has finished |
| cmdValid | output | 1 | A motion command is being presented |
| cmdOp | output | 3 | Opcode of the current word |
| cmdArg | output | ARG_W | Argument of the current word |

## Verification
The bound checker watches these rules on every cycle:
- the counter returns to zero after reset;
- a pending command stays frozen until done;
- the counter advances by exactly one after a handshake, after an untaken branch and after an undefined opcode;
- a taken branch and a jump land on the target field;
- `cmdValid` never rises on a control opcode.

Other behaviour shows only in the bench's scenarios, which run a cycle model against two instances: the default program and a second program that reaches undefined opcodes and the wrap from the last address. These scenarios show the exact program contents and field layout, and that a stray `cmdDone` during control words is ignored. They also show how sensor and handshake timing combine over long runs.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_FORW   = 3'd0,
    OP_BACK   = 3'd1,
    OP_ROTATE = 3'd2,
    OP_BNOOBS = 3'd3,
    OP_GOTO   = 3'd4
  } opcode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic step;   // load counter + 1
    logic jump;   // load target field
  } ctrl_t;

  // default program, word layout {op[2:0], arg[7:0], tgt[2:0]}
  localparam logic [8*14-1:0] DEFAULT_PROG = {
    {3'd4, 8'd0,  3'd0},   // 7: jump 0
    {3'd4, 8'd0,  3'd0},   // 6: jump 0
    {3'd4, 8'd0,  3'd0},   // 5: jump 0
    {3'd4, 8'd0,  3'd1},   // 4: jump 1
    {3'd2, 8'd90, 3'd0},   // 3: rotate 90
    {3'd1, 8'd10, 3'd0},   // 2: back 10
    {3'd3, 8'd0,  3'd0},   // 1: branch-if-clear 0
    {3'd0, 8'd35, 3'd0}    // 0: forward 35
  };

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int ARG_W  = 8,
  localparam int DEPTH  = 2 ** ADDR_W,
  localparam int WORD_W = OP_W + ARG_W + ADDR_W,
  parameter logic [DEPTH*WORD_W-1:0] PROG = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             strobes,
  output opcode_e           curOp,
  output logic [ARG_W-1:0]  curArg,
  output logic [ADDR_W-1:0] curTgt,
  output logic [ADDR_W-1:0] pc
);

  logic [WORD_W-1:0] rom [DEPTH];
  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] pcNext;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = PROG[i*WORD_W +: WORD_W];
  end

  assign word   = rom[pc];
  assign curOp  = opcode_e'(word[WORD_W-1 -: OP_W]);
  assign curArg = word[ADDR_W +: ARG_W];
  assign curTgt = word[ADDR_W-1:0];

  always_comb begin
    if (strobes.jump)      pcNext = curTgt;
    else if (strobes.step) pcNext = pc + 1'b1;
    else                   pcNext = pc;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic    rst,
  input  opcode_e curOp,
  input  logic    cmdDone,
  input  logic    noObstacle,
  output ctrl_t   strobes,
  output logic    cmdValid
);

  always_comb begin
    strobes  = '0;
    cmdValid = 1'b0;
    if (!rst) begin
      case (curOp)
        OP_FORW, OP_BACK, OP_ROTATE: begin
          cmdValid     = 1'b1;
          strobes.step = cmdDone;
        end
        OP_BNOOBS: begin
          strobes.jump = noObstacle;
          strobes.step = !noObstacle;
        end
        OP_GOTO: strobes.jump = 1'b1;
        default: strobes.step = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/motion_sequencer.sv
module motion_sequencer
  import seq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int ARG_W  = 8,
  localparam int DEPTH  = 2 ** ADDR_W,
  localparam int WORD_W = OP_W + ARG_W + ADDR_W,
  parameter logic [DEPTH*WORD_W-1:0] PROG = DEFAULT_PROG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             noObstacle,
  input  logic             cmdDone,
  output logic             cmdValid,
  output logic [OP_W-1:0]  cmdOp,
  output logic [ARG_W-1:0] cmdArg
);

  ctrl_t             strobes;
  opcode_e           curOp;
  logic [ADDR_W-1:0] curTgt;
  logic [ADDR_W-1:0] pc;

  seq_datapath #(.ADDR_W(ADDR_W), .ARG_W(ARG_W), .PROG(PROG)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .curOp(curOp), .curArg(cmdArg), .curTgt(curTgt), .pc(pc)
  );

  seq_control u_ctl (
    .rst(rst), .curOp(curOp), .cmdDone(cmdDone), .noObstacle(noObstacle),
    .strobes(strobes), .cmdValid(cmdValid)
  );

  assign cmdOp = curOp;

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int ADDR_W = 3,
  parameter int ARG_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              noObstacle,
  input logic              cmdDone,
  input logic              cmdValid,
  input logic [2:0]        cmdOp,
  input logic [ARG_W-1:0]  cmdArg,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] curTgt
);

  AST_RESET_PC_ZERO: assert property (@(posedge clk) rst |=> (pc == '0)); // R1

  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !cmdDone) |=> (cmdValid && $stable(cmdOp) && $stable(cmdArg) && $stable(pc))); // R3

  AST_ADVANCE_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdDone) |=> (pc == ADDR_W'($past(pc) + 1'b1))); // R4

  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (cmdOp == 3'd3 && noObstacle) |=> (pc == $past(curTgt))); // R5

  AST_BRANCH_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    (cmdOp == 3'd3 && !noObstacle) |=> (pc == ADDR_W'($past(pc) + 1'b1))); // R6

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (cmdOp == 3'd4) |=> (pc == $past(curTgt))); // R7

  AST_UNDEF_STEP: assert property (@(posedge clk) disable iff (rst)
    (cmdOp > 3'd4) |=> (pc == ADDR_W'($past(pc) + 1'b1))); // R8

  AST_VALID_MOTION_ONLY: assert property (@(posedge clk) disable iff (rst)
    cmdValid |-> (cmdOp < 3'd3)); // R3

endmodule

bind motion_sequencer seq_checker #(.ADDR_W(ADDR_W), .ARG_W(ARG_W)) u_chk (
  .clk(clk), .rst(rst), .noObstacle(noObstacle), .cmdDone(cmdDone),
  .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdArg(cmdArg), .pc(pc), .curTgt(curTgt)
);

// File: tb/motion_sequencer_tb.sv
`timescale 1ns/100ps
module motion_sequencer_tb;

  function automatic logic [13:0] mk(input int op, input int arg, input int tgt);
    return {op[2:0], arg[7:0], tgt[2:0]};
  endfunction

  // second program: undefined opcodes and wrap from address 7 (R2, R8, R10)
  localparam logic [111:0] ALT_PROG = {
    mk(0, 9, 0), mk(7, 8'hA5, 2), mk(4, 0, 7), mk(2, 3, 0),
    mk(3, 0, 6), mk(1, 2, 0), mk(5, 8'h55, 4), mk(0, 1, 0)
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic noObstacle = 1'b0;
  logic cmdDone = 1'b0;
  logic       vld [2];
  logic [2:0] opo [2];
  logic [7:0] argo [2];

  always #2 clk = ~clk;   // 250 MHz

  motion_sequencer u_dut (
    .clk(clk), .rst(rst), .noObstacle(noObstacle), .cmdDone(cmdDone),
    .cmdValid(vld[0]), .cmdOp(opo[0]), .cmdArg(argo[0])
  );

  motion_sequencer #(.PROG(ALT_PROG)) u_alt (
    .clk(clk), .rst(rst), .noObstacle(noObstacle), .cmdDone(cmdDone),
    .cmdValid(vld[1]), .cmdOp(opo[1]), .cmdArg(argo[1])
  );

  // reference model state
  int    mOp  [2][8];
  int    mArg [2][8];
  int    mTgt [2][8];
  int    mpc  [2];
  string tag  [2];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;

  initial begin
    // R11 default program
    int dOp[8]  = '{0, 3, 1, 2, 4, 4, 4, 4};
    int dArg[8] = '{35, 0, 10, 90, 0, 0, 0, 0};
    int dTgt[8] = '{0, 0, 0, 0, 1, 0, 0, 0};
    int aOp[8]  = '{0, 5, 1, 3, 2, 4, 7, 0};
    int aArg[8] = '{1, 'h55, 2, 0, 3, 0, 'hA5, 9};
    int aTgt[8] = '{0, 4, 0, 6, 0, 7, 2, 0};
    for (int i = 0; i < 8; i++) begin
      mOp[0][i] = dOp[i]; mArg[0][i] = dArg[i]; mTgt[0][i] = dTgt[i];
      mOp[1][i] = aOp[i]; mArg[1][i] = aArg[i]; mTgt[1][i] = aTgt[i];
    end
    mpc[0] = 0; mpc[1] = 0;
    tag[0] = "R1"; tag[1] = "R1";
  end

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      int op;
      int old;
      op  = mOp[k][mpc[k]];
      old = mpc[k];
      if (rst) begin
        mpc[k] = 0; tag[k] = "R1";
      end else if (op < 3) begin
        if (cmdDone) begin mpc[k] = (old + 1) % 8; tag[k] = "R4"; end
        else tag[k] = "R3";
      end else if (op == 3) begin
        if (noObstacle) begin mpc[k] = mTgt[k][old]; tag[k] = "R5"; end
        else begin mpc[k] = (old + 1) % 8; tag[k] = "R6"; end
      end else if (op == 4) begin
        mpc[k] = mTgt[k][old]; tag[k] = "R7";
      end else begin
        mpc[k] = (old + 1) % 8; tag[k] = "R8";
      end
      if (!rst && op >= 3 && cmdDone) tag[k] = {tag[k], "/R9"};
      if (!rst && old == 7 && mpc[k] == 0 && op != 4 && !(op == 3 && noObstacle))
        tag[k] = {tag[k], "/R10"};
    end
  end

  task automatic compare();
    for (int k = 0; k < 2; k++) begin
      int   op;
      logic ev;
      op = mOp[k][mpc[k]];
      ev = !rst && (op < 3);
      checks++;
      if (vld[k] !== ev || opo[k] !== op[2:0] || argo[k] !== mArg[k][mpc[k]][7:0]) begin
        fails++;
        $display("FAIL %s %s pc=%0d actual v=%b op=%0d arg=%0d expected v=%b op=%0d arg=%0d",
                 tag[k], (k == 0) ? "R11" : "R2", mpc[k], vld[k], opo[k], argo[k],
                 ev, op, mArg[k][mpc[k]]);
      end
    end
  endtask

  int lfsr = 16'hACE1;

  initial begin
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      rst = (c < 3) || (c >= 2000 && c < 2004);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]} & 16'hFFFF;
      cmdDone    = lfsr[0] & (lfsr[3] | (c > 3000));
      noObstacle = (c < 1000) ? lfsr[5] : (c < 1500) ? 1'b1 : (c < 1700) ? 1'b0 : lfsr[7];
      #0.5;
      compare();
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule